// File: doc/BRIEF.md
# Load-Use Interlock and Decode Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It compares the destination field of a load that occupies the decode/execute register against the two source fields of the instruction now being decoded. When the instruction needs a value that the load has not yet returned, the block holds the program counter and the fetch/decode register for one cycle. In the same cycle it makes the decode stage inject an all-zero control word. The stalled instruction is then decoded again one cycle later, and the forwarding path supplies the loaded value.

The block also raises the flush that clears the fetched instruction when a branch resolved in decode is taken. All outputs are combinational. They act on the pipeline registers at the next rising edge. A registered one-shot guard makes sure that no instruction is stalled twice in a row. While reset is asserted, every hold, bubble and flush is released.

Top module: `loaduse_hazard_unit`

## Requirements
- R1: When `ld_mem_rd` is 1, `ld_dst` is nonzero, `ld_dst` equals `dec_src_a` or `dec_src_b`, and the previous cycle was not a stall, the cycle is a stall.
- R2: In a stall cycle `pc_we` and `fd_we` are both 0 (0 = hold); in every other cycle after reset both are 1.
- R3: In a stall cycle `ctl_bubble` is 1 (1 = zero the execute, memory and write-back controls entering decode/execute); otherwise it is 0.
- R4: With `ld_mem_rd` at 0 no stall occurs, even when the fields match.
- R5: When `ld_dst` is register 0, no stall occurs, even with `ld_mem_rd` at 1 and matching source fields.
- R6: When `br_taken` is 1 and the cycle is not a stall, `fd_flush` is 1; with `br_taken` at 0, `fd_flush` is 0.
- R7: When a stall and `br_taken` coincide, the stall wins and `fd_flush` is 0.
- R8: A stall lasts exactly one cycle. In the cycle after a stall no stall is raised, even if the hazard condition is still presented.
- R9: While `rst_n` is 0, `pc_we` and `fd_we` are 1 and `ctl_bubble` and `fd_flush` are 0. After reset, the first hazard stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_mem_rd | input | 1 | Decode/execute instruction reads memory |
| ld_dst | input | REG_AW | Decode/execute rt (load destination) field |
| dec_src_a | input | REG_AW | Fetch/decode rs field |
| dec_src_b | input | REG_AW | Fetch/decode rt field |
| br_taken | input | 1 | Branch resolved in decode is taken |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| ctl_bubble | output | 1 | Select all-zero controls into decode/execute |
| fd_flush | output | 1 | Zero the instruction in fetch/decode |

## Verification
The assertions assume that the surrounding pipeline keeps every input stable between clock edges. They also assume that `br_taken` reflects a branch already in decode, with no relation required to the load fields. The stimulus drives every input shortly after a rising edge and samples at the falling edge, so the checks observe settled combinational values. Back-to-back hazard vectors are supplied on purpose, because the one-cycle property must hold even when the pipeline keeps presenting the same load after a bubble.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef struct packed {
      logic pc_we;
      logic fd_we;
      logic bubble;
      logic flush;
   } hz_ctl_t;

   localparam hz_ctl_t HZ_IDLE = '{pc_we: 1'b1, fd_we: 1'b1, bubble: 1'b0, flush: 1'b0};

   function automatic hz_ctl_t hz_compose(input logic stall, input logic flush_req);
      hz_ctl_t c;
      c.pc_we  = ~stall;
      c.fd_we  = ~stall;
      c.bubble = stall;
      c.flush  = flush_req & ~stall;
      return c;
   endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
   parameter int REG_AW      = 5,
   parameter int NUM_SRC     = 2,
   parameter bit ZERO_EXEMPT = 1'b1
) (
   input  logic                          rd_valid,
   input  logic [REG_AW-1:0]             rd_idx,
   input  logic [NUM_SRC-1:0][REG_AW-1:0] src_idx,
   output logic                          hit
);
   logic [NUM_SRC-1:0] per_src;
   logic               dst_live;

   generate
      if (ZERO_EXEMPT) begin : g_zero_exempt
         assign dst_live = rd_valid & (rd_idx != '0);
      end else begin : g_no_exempt
         assign dst_live = rd_valid;
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
         assign per_src[i] = (src_idx[i] == rd_idx);
      end
   endgenerate

   assign hit = dst_live & (|per_src);
endmodule

// File: rtl/hz_oneshot.sv
module hz_oneshot #(
   parameter bit GUARD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic grant
);
   generate
      if (GUARD) begin : g_guard
         logic held_q;
         always_ff @(posedge clk) begin
            if (!rst_n) held_q <= 1'b0;
            else        held_q <= grant;
         end
         assign grant = req & ~held_q & rst_n;
      end else begin : g_pass
         assign grant = req & rst_n;
      end
   endgenerate
endmodule

// File: rtl/loaduse_hazard_unit.sv
module loaduse_hazard_unit #(
   parameter int REG_AW      = 5,
   parameter bit ZERO_EXEMPT = 1'b1,
   parameter bit ONE_SHOT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_mem_rd,
   input  logic [REG_AW-1:0] ld_dst,
   input  logic [REG_AW-1:0] dec_src_a,
   input  logic [REG_AW-1:0] dec_src_b,
   input  logic              br_taken,
   output logic              pc_we,
   output logic              fd_we,
   output logic              ctl_bubble,
   output logic              fd_flush
);
   import hz_pkg::*;

   localparam int NUM_SRC = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("loaduse_hazard_unit: REG_AW must be 1..8");
      end
   endgenerate

   logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
   logic    hazard;
   logic    stall;
   hz_ctl_t ctl;

   assign srcs[0] = dec_src_a;
   assign srcs[1] = dec_src_b;

   hz_src_match #(
      .REG_AW     (REG_AW),
      .NUM_SRC    (NUM_SRC),
      .ZERO_EXEMPT(ZERO_EXEMPT)
   ) u_match (
      .rd_valid(ld_mem_rd),
      .rd_idx  (ld_dst),
      .src_idx (srcs),
      .hit     (hazard)
   );

   hz_oneshot #(.GUARD(ONE_SHOT)) u_guard (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (hazard),
      .grant(stall)
   );

   always_comb begin
      if (!rst_n) ctl = HZ_IDLE;
      else        ctl = hz_compose(stall, br_taken);
   end

   assign pc_we      = ctl.pc_we;
   assign fd_we      = ctl.fd_we;
   assign ctl_bubble = ctl.bubble;
   assign fd_flush   = ctl.flush;
endmodule

// File: rtl/loaduse_hazard_unit_chk.sv
module loaduse_hazard_unit_chk #(
   parameter int REG_AW   = 5,
   parameter bit ONE_SHOT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_mem_rd,
   input logic [REG_AW-1:0] ld_dst,
   input logic [REG_AW-1:0] dec_src_a,
   input logic [REG_AW-1:0] dec_src_b,
   input logic              br_taken,
   input logic              pc_we,
   input logic              fd_we,
   input logic              ctl_bubble,
   input logic              fd_flush
);
   logic match_now;
   assign match_now = ld_mem_rd && (ld_dst != '0) &&
                      ((ld_dst == dec_src_a) || (ld_dst == dec_src_b));

   assert_hazard_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (match_now && !$past(ctl_bubble)) |-> ctl_bubble);

   assert_hold_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_bubble |-> (!pc_we && !fd_we));

   assert_free_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_bubble |-> (pc_we && fd_we));

   assert_no_load_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_mem_rd |-> !ctl_bubble);

   assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_dst == '0) |-> !ctl_bubble);

   assert_flush_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken && !ctl_bubble) |-> fd_flush);

   assert_stall_beats_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_bubble |-> !fd_flush);

   generate
      if (ONE_SHOT) begin : g_one
         assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_bubble |=> !ctl_bubble);
      end
   endgenerate

   assert_reset_idle_R9: assert property (@(posedge clk)
      !rst_n |-> (pc_we && fd_we && !ctl_bubble && !fd_flush));
endmodule

bind loaduse_hazard_unit loaduse_hazard_unit_chk #(
   .REG_AW  (REG_AW),
   .ONE_SHOT(ONE_SHOT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_mem_rd (ld_mem_rd),
   .ld_dst    (ld_dst),
   .dec_src_a (dec_src_a),
   .dec_src_b (dec_src_b),
   .br_taken  (br_taken),
   .pc_we     (pc_we),
   .fd_we     (fd_we),
   .ctl_bubble(ctl_bubble),
   .fd_flush  (fd_flush)
);

// File: tb/loaduse_hazard_unit_bench.sv
module loaduse_hazard_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_mem_rd = 1'b0;
   logic [AW-1:0] ld_dst = '0;
   logic [AW-1:0] dec_src_a = '0;
   logic [AW-1:0] dec_src_b = '0;
   logic          br_taken = 1'b0;
   logic          pc_we, fd_we, ctl_bubble, fd_flush;

   typedef struct {
      logic  pc_we;
      logic  fd_we;
      logic  bubble;
      logic  flush;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   logic prev_stall = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   loaduse_hazard_unit #(.REG_AW(AW)) u_loaduse_hazard_unit (
      .clk(clk), .rst_n(rst_n), .ld_mem_rd(ld_mem_rd), .ld_dst(ld_dst),
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .br_taken(br_taken),
      .pc_we(pc_we), .fd_we(fd_we), .ctl_bubble(ctl_bubble), .fd_flush(fd_flush)
   );

   task automatic step(input logic rst, input logic mr, input int dst,
                       input int sa, input int sb, input logic br, input string tag);
      exp_t e;
      logic st;
      @(posedge clk);
      #1;
      rst_n = rst; ld_mem_rd = mr; ld_dst = AW'(dst);
      dec_src_a = AW'(sa); dec_src_b = AW'(sb); br_taken = br;
      st = rst && mr && (dst != 0) && (dst == sa || dst == sb) && !prev_stall;
      e.pc_we = !st; e.fd_we = !st; e.bubble = st;
      e.flush = rst && br && !st;
      e.tag = tag;
      exp_q.push_back(e);
      prev_stall = st;
   endtask

   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_run++;
         if ({pc_we, fd_we, ctl_bubble, fd_flush} !== {e.pc_we, e.fd_we, e.bubble, e.flush}) begin
            n_fail++;
            $display("FAIL %s: got pc_we=%b fd_we=%b bubble=%b flush=%b expected %b %b %b %b",
                     e.tag, pc_we, fd_we, ctl_bubble, fd_flush,
                     e.pc_we, e.fd_we, e.bubble, e.flush);
         end
      end
   end

   initial begin
      step(0, 1, 3, 3, 3, 1, "R9 reset idle with hazard");
      step(0, 1, 3, 3, 0, 0, "R9 reset idle");
      step(1, 1, 3, 3, 0, 0, "R9 first hazard after reset");
      step(1, 0, 0, 0, 0, 0, "R2 free run");
      step(1, 1, 7, 1, 7, 0, "R1 match on rt source");
      step(1, 0, 7, 1, 7, 0, "R2 release after stall");
      step(1, 1, 9, 9, 2, 0, "R3 match on rs source");
      step(1, 1, 9, 9, 2, 0, "R8 repeat hazard not stalled");
      step(1, 1, 9, 9, 2, 0, "R1 hazard stalls again after gap");
      step(1, 0, 0, 0, 0, 0, "R2 idle");
      step(1, 0, 4, 4, 4, 0, "R4 no read no stall");
      step(1, 1, 0, 0, 0, 0, "R5 register zero exempt");
      step(1, 1, 5, 6, 8, 0, "R1 no match no stall");
      step(1, 0, 0, 1, 2, 1, "R6 taken branch flushes");
      step(1, 1, 12, 12, 1, 1, "R7 stall beats flush");
      step(1, 1, 12, 12, 1, 1, "R6 flush after stall with guard");
      step(1, 0, 0, 0, 0, 0, "R6 no branch no flush");
      step(1, 1, 31, 2, 31, 0, "R1 top register index");
      step(0, 1, 31, 2, 31, 1, "R9 reset mid-run");
      step(1, 1, 31, 31, 31, 0, "R9 guard cleared by reset");
      step(1, 0, 0, 0, 0, 0, "R2 idle tail");
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 2000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule